// File: doc/BRIEF.md
# Boundary-Scan Pad Register Chain

This block is the pad-side data register of a boundary-scan test port. It puts one group of scan cells next to each I/O pad and links every cell into a single serial path from `tdi` to `tdo`. A bidirectional pad gets three cells: one that observes the pad's input, one that can drive its output value, and one that can drive its output enable. A pad that can only receive gets a single observing cell. Because the pad list is fixed by parameters, the length and bit order of the path depend only on that list and never on the logic in the core.

A test controller that is not part of this block drives plain strobes on the rising edge of `tck`. A capture strobe samples the live pad and core values into the shift stages. A shift strobe moves the path one place toward `tdo`. An update strobe copies the shift stages into a second rank of holding registers. While either the internal-test or the external-test mode input is high, the holding registers take over the output value and enable of every bidirectional pad. While the internal-test mode is high, the input cells' holding registers also take over the value the core sees. When no test mode is active, pads and core are connected straight through. The serial path has no handshake: it moves on every `tck` edge on which the shift strobe is high, and it cannot apply back-pressure.

Top module: `bsr_chain`

## Requirements
- R1: The path length is 3 cells per bidirectional pad plus 1 per input-only pad (10 with the defaults). A bit entering at `tdi` appears on `tdo` after exactly that many shift edges.
- R2: Pad 0 is nearest `tdi`. Within a bidirectional pad, the cells run input cell, then output-value cell, then output-enable cell, so the enable cell of the last pad is the bit on `tdo`.
- R3: An input-only pad (a 0 bit in `BIDIR_MASK`) adds just its input cell to the path.
- R4: On a `tck` edge with `capture_dr` high, each input cell loads `pad_in`, each output-value cell loads `core_out` and each enable cell loads `core_oe` of its pad. Capture takes precedence over shift.
- R5: On a `tck` edge with `shift_dr` high and `capture_dr` low, each cell loads its predecessor, the first cell loads `tdi`, and `tdo` shows the last cell.
- R6: On a `tck` edge with `update_dr` high, each holding register loads its shift stage. Otherwise the holding registers keep their value, whatever the shift stages do.
- R7: While `intest` or `extest` is high, a bidirectional pad's `pad_out` and `pad_oe` come from its output-value and enable holding registers.
- R8: While `intest` and `extest` are both low, a bidirectional pad's `pad_out` and `pad_oe` equal `core_out` and `core_oe`.
- R9: While `trst_n` is low, all shift stages and holding registers are cleared to 0.
- R10: For an input-only pad, `pad_out` and `pad_oe` always follow `core_out` and `core_oe`, in every mode.
- R11: On an edge with neither `capture_dr` nor `shift_dr` high, the shift stages keep their contents.
- R12: While `intest` is high, `core_in` of each pad comes from its input-cell holding register. Otherwise it equals `pad_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock, all registers act on its rising edge |
| trst_n | input | 1 | Asynchronous active-low clear of all cells |
| tdi | input | 1 | Serial data into the first cell |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| intest | input | 1 | Internal-test mode select |
| extest | input | 1 | External-test mode select |
| pad_in | input | NUM_PADS | Value received at each pad |
| core_out | input | NUM_PADS | Output value the core drives for each pad |
| core_oe | input | NUM_PADS | Output enable the core drives for each pad |
| tdo | output | 1 | Serial data from the last cell |
| pad_out | output | NUM_PADS | Output value sent to each pad |
| pad_oe | output | NUM_PADS | Output enable sent to each pad |
| core_in | output | NUM_PADS | Pad value presented to the core |

## Verification
Two capture patterns are used, each with distinct values on the pad inputs and on the core-side value and enable. They separate every cell's position, so a swap between the value and enable cells, or a misplaced input-only cell, shows up as a wrong bit. A non-periodic serial stream flushed through the path pins the shift latency to exactly the path length. An update pattern is loaded and then read back under each mode setting, which separates internal-test from external-test from pass-through. A second shift that is not followed by an update, a cycle with capture and shift both high, and idle cycles between shifts show whether the holding registers, the capture precedence and the hold rule behave correctly.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  // cell index inside a bidirectional group, counted from the tdi side
  localparam int IN_CELL  = 0;
  localparam int OUT_CELL = 1;
  localparam int OE_CELL  = 2;

  localparam int BIDIR_CELLS  = 3;
  localparam int INONLY_CELLS = 1;

  // position of the first cell of pad `pad` (also the total length when pad == count)
  function automatic int chain_offset(logic [31:0] mask, int pad);
    int off;
    off = 0;
    for (int q = 0; q < pad; q++) begin
      off += mask[q] ? BIDIR_CELLS : INONLY_CELLS;
    end
    return off;
  endfunction

endpackage

// File: rtl/bsr_cell.sv
module bsr_cell (
  input  logic tck,
  input  logic trst_n,
  input  logic capture,
  input  logic shift,
  input  logic update,
  input  logic si,
  input  logic cap_d,
  output logic sh_q,
  output logic up_q
);

  // shift stage: capture wins over shift
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sh_q <= 1'b0;
    end else if (capture) begin
      sh_q <= cap_d;
    end else if (shift) begin
      sh_q <= si;
    end
  end

  // holding stage, loaded only on update
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      up_q <= 1'b0;
    end else if (update) begin
      up_q <= sh_q;
    end
  end

endmodule

// File: rtl/bsr_pad_group.sv
module bsr_pad_group #(
  parameter int CELLS = 3
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             capture,
  input  logic             shift,
  input  logic             update,
  input  logic             si,
  input  logic [CELLS-1:0] cap_d,
  output logic [CELLS-1:0] sh,
  output logic [CELLS-1:0] up
);

  for (genvar k = 0; k < CELLS; k++) begin : g_cell
    logic link;
    if (k == 0) begin : g_first
      assign link = si;
    end else begin : g_next
      assign link = sh[k-1];
    end

    bsr_cell u_cell (
      .tck     (tck),
      .trst_n  (trst_n),
      .capture (capture),
      .shift   (shift),
      .update  (update),
      .si      (link),
      .cap_d   (cap_d[k]),
      .sh_q    (sh[k]),
      .up_q    (up[k])
    );
  end

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import bsr_pkg::*;
#(
  parameter int          NUM_PADS   = 4,
  parameter logic [31:0] BIDIR_MASK = 32'h0000_000D
) (
  input  logic                tck,
  input  logic                trst_n,
  input  logic                tdi,
  input  logic                capture_dr,
  input  logic                shift_dr,
  input  logic                update_dr,
  input  logic                intest,
  input  logic                extest,
  input  logic [NUM_PADS-1:0] pad_in,
  input  logic [NUM_PADS-1:0] core_out,
  input  logic [NUM_PADS-1:0] core_oe,
  output logic                tdo,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  output logic [NUM_PADS-1:0] core_in
);

  localparam int LEN = chain_offset(BIDIR_MASK, NUM_PADS);

  logic [LEN-1:0] chain_q;
  logic [LEN-1:0] upd_q;
  logic           ovr;

  assign ovr = intest | extest;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam int OFF   = chain_offset(BIDIR_MASK, p);
    localparam bit BIDIR = BIDIR_MASK[p];
    localparam int W     = BIDIR ? BIDIR_CELLS : INONLY_CELLS;

    logic         si;
    logic [W-1:0] cap_d;
    logic [W-1:0] sh;
    logic [W-1:0] up;

    if (p == 0) begin : g_head
      assign si = tdi;
    end else begin : g_link
      assign si = chain_q[OFF-1];
    end

    if (BIDIR) begin : g_bidir
      assign cap_d      = {core_oe[p], core_out[p], pad_in[p]};
      assign pad_out[p] = ovr ? up[OUT_CELL] : core_out[p];
      assign pad_oe[p]  = ovr ? up[OE_CELL]  : core_oe[p];
    end else begin : g_inonly
      assign cap_d      = pad_in[p];
      assign pad_out[p] = core_out[p];
      assign pad_oe[p]  = core_oe[p];
    end

    assign core_in[p] = intest ? up[IN_CELL] : pad_in[p];

    bsr_pad_group #(.CELLS(W)) u_grp (
      .tck     (tck),
      .trst_n  (trst_n),
      .capture (capture_dr),
      .shift   (shift_dr),
      .update  (update_dr),
      .si      (si),
      .cap_d   (cap_d),
      .sh      (sh),
      .up      (up)
    );

    assign chain_q[OFF +: W] = sh;
    assign upd_q[OFF +: W]   = up;
  end

  assign tdo = chain_q[LEN-1];

endmodule

// File: rtl/bsr_chain_chk.sv
module bsr_chain_chk
  import bsr_pkg::*;
#(
  parameter int          NUM_PADS   = 4,
  parameter logic [31:0] BIDIR_MASK = 32'h0000_000D,
  parameter int          LEN        = chain_offset(BIDIR_MASK, NUM_PADS)
) (
  input logic                tck,
  input logic                trst_n,
  input logic                tdi,
  input logic                capture_dr,
  input logic                shift_dr,
  input logic                update_dr,
  input logic                intest,
  input logic                extest,
  input logic [NUM_PADS-1:0] pad_in,
  input logic [NUM_PADS-1:0] core_out,
  input logic [NUM_PADS-1:0] core_oe,
  input logic                tdo,
  input logic [NUM_PADS-1:0] pad_out,
  input logic [NUM_PADS-1:0] pad_oe,
  input logic [NUM_PADS-1:0] core_in,
  input logic [LEN-1:0]      chain_q,
  input logic [LEN-1:0]      upd_q
);

  assert_shift_step_R5: assert property (@(posedge tck) disable iff (!trst_n)
    (shift_dr && !capture_dr) |=> chain_q == {$past(chain_q[LEN-2:0]), $past(tdi)});

  assert_hold_idle_R11: assert property (@(posedge tck) disable iff (!trst_n)
    (!shift_dr && !capture_dr) |=> $stable(chain_q));

  assert_update_load_R6: assert property (@(posedge tck) disable iff (!trst_n)
    update_dr |=> upd_q == $past(chain_q));

  assert_update_hold_R6: assert property (@(posedge tck) disable iff (!trst_n)
    !update_dr |=> $stable(upd_q));

  assert_capture_first_R4: assert property (@(posedge tck) disable iff (!trst_n)
    capture_dr |=> chain_q[0] == $past(pad_in[0]));

  if (BIDIR_MASK[NUM_PADS-1]) begin : g_last_bidir
    assert_capture_tdo_R2: assert property (@(posedge tck) disable iff (!trst_n)
      capture_dr |=> tdo == $past(core_oe[NUM_PADS-1]));
  end else begin : g_last_inonly
    assert_capture_tdo_R3: assert property (@(posedge tck) disable iff (!trst_n)
      capture_dr |=> tdo == $past(pad_in[NUM_PADS-1]));
  end

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam int OFF = chain_offset(BIDIR_MASK, p);
    if (BIDIR_MASK[p]) begin : g_bidir
      assert_override_R7: assert property (@(posedge tck) disable iff (!trst_n)
        (intest || extest) |-> (pad_out[p] == upd_q[OFF+OUT_CELL] &&
                                pad_oe[p]  == upd_q[OFF+OE_CELL]));
      assert_passthru_R8: assert property (@(posedge tck) disable iff (!trst_n)
        (!intest && !extest) |-> (pad_out[p] == core_out[p] && pad_oe[p] == core_oe[p]));
    end else begin : g_inonly
      assert_inonly_follow_R10: assert property (@(posedge tck) disable iff (!trst_n)
        (pad_out[p] == core_out[p] && pad_oe[p] == core_oe[p]));
    end
    assert_core_in_R12: assert property (@(posedge tck) disable iff (!trst_n)
      core_in[p] == (intest ? upd_q[OFF+IN_CELL] : pad_in[p]));
  end

endmodule

bind bsr_chain bsr_chain_chk #(
  .NUM_PADS   (NUM_PADS),
  .BIDIR_MASK (BIDIR_MASK)
) u_chk (
  .tck        (tck),
  .trst_n     (trst_n),
  .tdi        (tdi),
  .capture_dr (capture_dr),
  .shift_dr   (shift_dr),
  .update_dr  (update_dr),
  .intest     (intest),
  .extest     (extest),
  .pad_in     (pad_in),
  .core_out   (core_out),
  .core_oe    (core_oe),
  .tdo        (tdo),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .core_in    (core_in),
  .chain_q    (chain_q),
  .upd_q      (upd_q)
);

// File: tb/bsr_chain_tb.sv
`timescale 1ns/1ps
module bsr_chain_tb;

  localparam int          N    = 4;
  localparam logic [31:0] MASK = 32'h0000_000D;
  localparam int          LEN  = 10;

  logic         tck = 1'b0;
  logic         trst_n = 1'b0;
  logic         tdi = 1'b0;
  logic         capture_dr = 1'b0;
  logic         shift_dr = 1'b0;
  logic         update_dr = 1'b0;
  logic         intest = 1'b0;
  logic         extest = 1'b0;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] core_out = '0;
  logic [N-1:0] core_oe = '0;
  logic         tdo;
  logic [N-1:0] pad_out;
  logic [N-1:0] pad_oe;
  logic [N-1:0] core_in;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 tck = ~tck;

  bsr_chain #(.NUM_PADS(N), .BIDIR_MASK(MASK)) u_dut (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .intest(intest), .extest(extest),
    .pad_in(pad_in), .core_out(core_out), .core_oe(core_oe),
    .tdo(tdo), .pad_out(pad_out), .pad_oe(pad_oe), .core_in(core_in)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // first cell of each pad: 3 cells per bidirectional pad, 1 per input-only pad
  function automatic int off_of(int p);
    int o = 0;
    for (int q = 0; q < p; q++) o += MASK[q] ? 3 : 1;
    return o;
  endfunction

  function automatic logic [LEN-1:0] cap_model(logic [N-1:0] pi, logic [N-1:0] co, logic [N-1:0] ce);
    logic [LEN-1:0] v = '0;
    for (int p = 0; p < N; p++) begin
      v[off_of(p)] = pi[p];
      if (MASK[p]) begin
        v[off_of(p)+1] = co[p];
        v[off_of(p)+2] = ce[p];
      end
    end
    return v;
  endfunction

  task automatic step();
    @(posedge tck);
    @(negedge tck);
  endtask

  // shift the whole path once: v lands in place, got is what was there
  task automatic scan(input logic [LEN-1:0] v, output logic [LEN-1:0] got);
    for (int k = 0; k < LEN; k++) begin
      got[LEN-1-k] = tdo;
      tdi = v[LEN-1-k];
      shift_dr = 1'b1;
      step();
    end
    shift_dr = 1'b0;
    tdi = 1'b0;
  endtask

  task automatic pulse_update();
    update_dr = 1'b1;
    step();
    update_dr = 1'b0;
  endtask

  task automatic pulse_capture();
    capture_dr = 1'b1;
    step();
    capture_dr = 1'b0;
  endtask

  task automatic check_pads(input logic [LEN-1:0] u, input string req);
    logic [N-1:0] eo, ee, ei;
    bit ov;
    ov = intest | extest;
    for (int p = 0; p < N; p++) begin
      eo[p] = (MASK[p] && ov) ? u[off_of(p)+1] : core_out[p];
      ee[p] = (MASK[p] && ov) ? u[off_of(p)+2] : core_oe[p];
      ei[p] = intest ? u[off_of(p)] : pad_in[p];
    end
    check(pad_out == eo, {req, " pad_out"}, 64'(pad_out), 64'(eo));
    check(pad_oe == ee, {req, " pad_oe"}, 64'(pad_oe), 64'(ee));
    check(core_in == ei, {req, " core_in"}, 64'(core_in), 64'(ei));
  endtask

  task automatic t_reset();
    logic [LEN-1:0] got;
    core_out = 4'b1111; core_oe = 4'b1111; extest = 1'b1;
    @(negedge tck);
    check(tdo == 1'b0, "R9 tdo after reset", 64'(tdo), 64'd0);
    check_pads('0, "R9/R10 reset override");
    extest = 1'b0;
    scan('0, got);
    check(got == '0, "R9 shift stages cleared", 64'(got), 64'd0);
  endtask

  task automatic t_capture(input logic [N-1:0] pi, input logic [N-1:0] co, input logic [N-1:0] ce);
    logic [LEN-1:0] got, exp;
    pad_in = pi; core_out = co; core_oe = ce;
    exp = cap_model(pi, co, ce);
    pulse_capture();
    check(tdo == ce[N-1], "R2 enable cell of last pad on tdo", 64'(tdo), 64'(ce[N-1]));
    scan('0, got);
    check(got == exp, "R4/R2 captured order", 64'(got), 64'(exp));
    check(got[3] == pi[1], "R3 input-only pad single cell", 64'(got[3]), 64'(pi[1]));
    check(got[4] == pi[2], "R3 next pad follows directly", 64'(got[4]), 64'(pi[2]));
  endtask

  task automatic t_latency();
    logic [2*LEN-1:0] seq;
    bit ok;
    seq = 20'hB3_C5D ^ 20'h0_0A17;
    ok = 1'b1;
    for (int k = 0; k < 2*LEN; k++) begin
      if (k >= LEN) check(tdo == seq[k-LEN], "R1 tdi to tdo latency", 64'(tdo), 64'(seq[k-LEN]));
      else if (tdo != 1'b0) ok = 1'b0;
      tdi = seq[k];
      shift_dr = 1'b1;
      step();
    end
    shift_dr = 1'b0;
    check(ok, "R1 no early bits on tdo", 64'(ok), 64'd1);
  endtask

  task automatic t_update_modes();
    logic [LEN-1:0] got, u, u2;
    u = 10'b10_1101_0110;
    pad_in = 4'b0101; core_out = 4'b0011; core_oe = 4'b1100;
    scan(u, got);
    pulse_update();
    extest = 1'b1; intest = 1'b0; @(negedge tck);
    check_pads(u, "R7 extest override");
    extest = 1'b0; intest = 1'b1; @(negedge tck);
    check_pads(u, "R7/R12 intest override");
    intest = 1'b0; @(negedge tck);
    check_pads(u, "R8/R12 pass-through");
    core_out = 4'b1010; core_oe = 4'b0110; @(negedge tck);
    check_pads(u, "R8/R10 pass-through follows core");
    // new shift without update must not disturb held values
    u2 = ~u;
    scan(u2, got);
    check(got == u, "R5 shift-out of loaded pattern", 64'(got), 64'(u));
    extest = 1'b1; @(negedge tck);
    check_pads(u, "R6 hold without update");
    pulse_update();
    check_pads(u2, "R6 new update applied");
    extest = 1'b0;
  endtask

  task automatic t_priority();
    logic [LEN-1:0] got, exp;
    pad_in = 4'b1001; core_out = 4'b0110; core_oe = 4'b1011;
    exp = cap_model(pad_in, core_out, core_oe);
    capture_dr = 1'b1; shift_dr = 1'b1; tdi = 1'b1;
    step();
    capture_dr = 1'b0; shift_dr = 1'b0; tdi = 1'b0;
    scan('0, got);
    check(got == exp, "R4 capture over shift", 64'(got), 64'(exp));
  endtask

  task automatic t_idle();
    logic [LEN-1:0] got, v;
    v = 10'b01_1001_1101;
    scan(v, got);
    repeat (5) begin
      tdi = ~tdi;
      step();
    end
    tdi = 1'b0;
    check(tdo == v[LEN-1], "R11 tdo held while idle", 64'(tdo), 64'(v[LEN-1]));
    scan('0, got);
    check(got == v, "R11 contents held while idle", 64'(got), 64'(v));
  endtask

  task automatic t_reset_mid();
    logic [LEN-1:0] got;
    scan('1, got);
    pulse_update();
    trst_n = 1'b0;
    extest = 1'b1;
    @(negedge tck);
    check_pads('0, "R9 clear mid-run");
    check(tdo == 1'b0, "R9 tdo cleared", 64'(tdo), 64'd0);
    trst_n = 1'b1;
    extest = 1'b0;
    @(negedge tck);
  endtask

  initial begin
    repeat (3) @(negedge tck);
    trst_n = 1'b1;
    @(negedge tck);
    t_reset();
    t_capture(4'b1010, 4'b0110, 4'b1001);
    t_capture(4'b0101, 4'b1001, 4'b0110);
    t_latency();
    t_update_modes();
    t_priority();
    t_idle();
    t_reset_mid();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule